// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block is a traffic source for link testing. It emits complete MAC frames one byte per clock, with a valid flag and flags that mark the first and last byte of each frame. Every frame carries a preamble and start delimiter, a header built from configured addresses and a length/type value, a payload drawn from one of four fixed patterns, zero padding up to the minimum frame size, and a CRC-32 frame check sequence. A configured number of idle cycles separates frames.

A start pulse captures the whole configuration and begins a run of a configured number of frames, or an endless run when that number is zero. The block can also corrupt the check sequence on purpose so that a receiver under test sees bad frames.

Top module: `eth_test_gen`

## Requirements
- R1: After reset, tx_valid, tx_sof, tx_eof and busy are all 0.
- R2: The first frame byte appears in the cycle after the one in which start is sampled high while idle. A frame opens with 7 bytes of 0x55, with tx_sof set on the first of them, followed by one byte of 0xD5.
- R3: After 0xD5 the header is sent: cfg_dst with its most significant byte first, then cfg_src in the same order, then the length/type field with its high byte first. Because cfg_dst[47:40] is sent first, its bit 40 is the group/unicast bit, and it is sent as configured.
- R4: If cfg_lentype is 1536 or more it is sent unchanged. Otherwise the field sent is the effective payload length.
- R5: A cfg_pay_len above 1500 is treated as 1500. The effective payload length is used both for the data and for the length field.
- R6: If the effective payload is shorter than 46 bytes, bytes of 0x00 follow it until the data and pad together make 46 bytes.
- R7: cfg_pattern selects the payload. 0 sends the byte index from 0, modulo 256. 1 sends 0x00. 2 sends 0xFF. 3 sends {0, s}, where s is a 7-bit register set to 0x7F at the start of each frame and stepped after each byte to {s[5:0], s[6]^s[5]}.
- R8: Four check bytes follow the pad. They hold the CRC-32 over the header, data and pad, computed as follows: reflected polynomial 0xEDB88320, start value all ones, least significant bit first, result inverted. They are sent low byte first, and tx_eof is set on the last one.
- R9: When cfg_err_inj is 1, bit 0 of the last check byte is inverted.
- R10: Between tx_eof and the next tx_sof of a run there are exactly max(cfg_gap, 12) cycles with tx_valid low.
- R11: A run sends exactly cfg_frames frames and then busy falls. A cfg_frames of 0 runs without end until reset.
- R12: All configuration is captured at start. Configuration changes and start pulses while busy is 1 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| cfg_dst | input | 48 | Destination address |
| cfg_src | input | 48 | Source address |
| cfg_lentype | input | 16 | Length/type value |
| cfg_pay_len | input | 11 | Payload length in bytes |
| cfg_pattern | input | 2 | Payload pattern select |
| cfg_frames | input | 16 | Frames per run, 0 for endless |
| cfg_gap | input | 8 | Idle cycles between frames |
| cfg_err_inj | input | 1 | Corrupt the check sequence |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | tx_data holds a frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| busy | output | 1 | A run is in progress |

## Verification
The first preamble byte is due exactly one cycle after start is sampled. After that, one expected byte falls due in every cycle in which tx_valid is high. The gap is due as a fixed count of low-valid cycles after each tx_eof, and busy is due to fall once the last gap has elapsed. The driver queues every expected byte, with its flags, before it pulses start. The monitor samples on the falling clock edge, compares each valid byte to the head of the queue in arrival order, and counts the idle cycles between frames, so that a byte arriving one cycle early or late shows up as a mismatch. At the end of each run the driver checks that the queue is empty and that the right number of frames arrived.

// File: rtl/eth_test_gen.sv
module eth_test_gen #(
  parameter int PRE_LEN  = 7,
  parameter int MIN_GAP  = 12,
  parameter int MAX_PAY  = 1500,
  parameter int MIN_BODY = 46,
  parameter int TYPE_MIN = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] cfg_dst,
  input  logic [47:0] cfg_src,
  input  logic [15:0] cfg_lentype,
  input  logic [10:0] cfg_pay_len,
  input  logic [1:0]  cfg_pattern,
  input  logic [15:0] cfg_frames,
  input  logic [7:0]  cfg_gap,
  input  logic        cfg_err_inj,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_sof,
  output logic        tx_eof,
  output logic        busy
);
  localparam logic [10:0] PRE_LAST = 11'(PRE_LEN);
  localparam logic [10:0] PAY_MAX  = 11'(MAX_PAY);
  localparam logic [10:0] BODY_MIN = 11'(MIN_BODY);
  localparam logic [7:0]  GAP_MIN  = 8'(MIN_GAP);
  localparam logic [15:0] LT_TYPE  = 16'(TYPE_MIN);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_HDR, S_BODY, S_FCS, S_GAP} st_t;
  st_t st;

  logic [10:0]  cnt, r_len;
  logic [31:0]  crc;
  logic [6:0]   prbs;
  logic [15:0]  left, r_lt;
  logic [47:0]  r_dst, r_src;
  logic [1:0]   r_pat;
  logic [7:0]   r_gap;
  logic         r_err, r_cont;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    x = c ^ {24'b0, d};
    for (int i = 0; i < 8; i++)
      x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
    return x;
  endfunction

  wire [10:0]  len_eff  = (cfg_pay_len > PAY_MAX) ? PAY_MAX : cfg_pay_len;
  wire [10:0]  body_len = (r_len < BODY_MIN) ? BODY_MIN : r_len;
  wire [111:0] hdr_bits = {r_dst, r_src, r_lt};
  wire [111:0] hdr_sh   = hdr_bits >> {(4'd13 - cnt[3:0]), 3'b000};
  wire [31:0]  fcs      = ~crc;
  wire [31:0]  fcs_sh   = fcs >> {cnt[1:0], 3'b000};

  logic [7:0] pat_byte;
  always_comb begin
    case (r_pat)
      2'd0:    pat_byte = cnt[7:0];
      2'd1:    pat_byte = 8'h00;
      2'd2:    pat_byte = 8'hFF;
      default: pat_byte = {1'b0, prbs};
    endcase
  end

  always_comb begin
    case (st)
      S_PRE:   tx_data = (cnt == PRE_LAST) ? 8'hD5 : 8'h55;
      S_HDR:   tx_data = hdr_sh[7:0];
      S_BODY:  tx_data = (cnt < r_len) ? pat_byte : 8'h00;
      S_FCS:   tx_data = fcs_sh[7:0] ^ {7'b0, r_err && cnt[1:0] == 2'd3};
      default: tx_data = 8'h00;
    endcase
  end

  assign tx_valid = (st == S_PRE) || (st == S_HDR) || (st == S_BODY) || (st == S_FCS);
  assign tx_sof   = (st == S_PRE) && (cnt == 11'd0);
  assign tx_eof   = (st == S_FCS) && (cnt[1:0] == 2'd3);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; crc <= '1; prbs <= 7'h7F; left <= '0;
      r_dst <= '0; r_src <= '0; r_lt <= '0; r_len <= '0; r_pat <= '0;
      r_gap <= GAP_MIN; r_err <= 1'b0; r_cont <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          r_dst  <= cfg_dst;
          r_src  <= cfg_src;
          r_len  <= len_eff;
          r_lt   <= (cfg_lentype >= LT_TYPE) ? cfg_lentype : {5'b0, len_eff};
          r_pat  <= cfg_pattern;
          r_gap  <= (cfg_gap < GAP_MIN) ? GAP_MIN : cfg_gap;
          r_err  <= cfg_err_inj;
          r_cont <= (cfg_frames == 16'd0);
          left   <= cfg_frames;
          cnt    <= '0;
          st     <= S_PRE;
        end
        S_PRE: begin
          crc  <= '1;
          prbs <= 7'h7F;
          if (cnt == PRE_LAST) begin cnt <= '0; st <= S_HDR; end
          else cnt <= cnt + 11'd1;
        end
        S_HDR: begin
          crc <= crc_step(crc, tx_data);
          if (cnt == 11'd13) begin cnt <= '0; st <= S_BODY; end
          else cnt <= cnt + 11'd1;
        end
        S_BODY: begin
          crc <= crc_step(crc, tx_data);
          if (cnt < r_len) prbs <= {prbs[5:0], prbs[6] ^ prbs[5]};
          if (cnt == body_len - 11'd1) begin cnt <= '0; st <= S_FCS; end
          else cnt <= cnt + 11'd1;
        end
        S_FCS: begin
          if (cnt[1:0] == 2'd3) begin
            cnt <= '0;
            st  <= S_GAP;
            if (!r_cont) left <= left - 16'd1;
          end else cnt <= cnt + 11'd1;
        end
        S_GAP: begin
          if (cnt == {3'b0, r_gap} - 11'd1) begin
            cnt <= '0;
            st  <= (r_cont || left != 16'd0) ? S_PRE : S_IDLE;
          end else cnt <= cnt + 11'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  sof_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |=> tx_valid && !tx_sof && tx_data == 8'h55);
  // R8
  eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |-> tx_valid && !tx_sof);
  // R10
  gap_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |=> !tx_valid && busy);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !tx_sof && !tx_eof);
  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> $stable(r_len) && $stable(r_dst) && $stable(r_pat));
endmodule

// File: tb/eth_test_gen_tb.sv
module eth_test_gen_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, cfg_err_inj;
  logic [47:0] cfg_dst, cfg_src;
  logic [15:0] cfg_lentype, cfg_frames;
  logic [10:0] cfg_pay_len;
  logic [1:0]  cfg_pattern;
  logic [7:0]  cfg_gap, tx_data;
  logic        tx_valid, tx_sof, tx_eof, busy;

  eth_test_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dst(cfg_dst), .cfg_src(cfg_src),
    .cfg_lentype(cfg_lentype), .cfg_pay_len(cfg_pay_len), .cfg_pattern(cfg_pattern),
    .cfg_frames(cfg_frames), .cfg_gap(cfg_gap), .cfg_err_inj(cfg_err_inj),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof), .busy(busy)
  );

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  int exp_gap = 12, frames_seen = 0, idle_run = 0;
  bit seen_eof = 0;
  logic [9:0] mon_e;
  string      mon_t;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] x = c;
    for (int i = 0; i < 8; i++) begin
      if (x[0] ^ b[i]) x = (x >> 1) ^ 32'hEDB88320;
      else x = x >> 1;
    end
    return x;
  endfunction

  task automatic push(input logic [7:0] b, input bit s, input bit e, input string t);
    exp_q.push_back({s, e, b});
    tag_q.push_back(t);
  endtask

  task automatic build(input logic [47:0] d, input logic [47:0] s, input logic [15:0] lt,
                       input int len, input int pat, input bit err);
    int n = (len > 1500) ? 1500 : len;
    int body = (n < 46) ? 46 : n;
    logic [15:0] lf = (lt >= 16'd1536) ? lt : 16'(n);
    logic [31:0] c = '1;
    logic [6:0] p = 7'h7F;
    logic [7:0] b;
    for (int i = 0; i < 7; i++) push(8'h55, i == 0, 1'b0, "R2");
    push(8'hD5, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 6; i++) begin b = d[47 - 8*i -: 8]; push(b, 0, 0, "R3"); c = upd(c, b); end
    for (int i = 0; i < 6; i++) begin b = s[47 - 8*i -: 8]; push(b, 0, 0, "R3"); c = upd(c, b); end
    push(lf[15:8], 0, 0, "R4"); c = upd(c, lf[15:8]);
    push(lf[7:0], 0, 0, "R4");  c = upd(c, lf[7:0]);
    for (int i = 0; i < body; i++) begin
      if (i < n) begin
        case (pat)
          0: b = 8'(i);
          1: b = 8'h00;
          2: b = 8'hFF;
          default: begin b = {1'b0, p}; p = {p[5:0], p[6] ^ p[5]}; end
        endcase
        push(b, 0, 0, (len > 1500) ? "R5" : "R7");
      end else begin
        b = 8'h00;
        push(b, 0, 0, "R6");
      end
      c = upd(c, b);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) begin
      b = c[8*k +: 8];
      if (k == 3 && err) b = b ^ 8'h01;
      push(b, 1'b0, k == 3, err ? "R9" : "R8");
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      seen_eof = 0; idle_run = 0;
    end else if (tx_valid) begin
      if (tx_sof && seen_eof) chk(idle_run == exp_gap, "R10", "gap cycles", idle_run, exp_gap);
      if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected byte", int'(tx_data), 0);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk({tx_sof, tx_eof, tx_data} == mon_e, mon_t, "sof/eof/byte",
            int'({tx_sof, tx_eof, tx_data}), int'(mon_e));
      end
      if (tx_eof) begin seen_eof = 1; frames_seen++; idle_run = 0; end
    end else begin
      idle_run++;
      if (!busy) seen_eof = 0;
    end
  end

  task automatic run(input logic [47:0] d, input logic [47:0] s, input logic [15:0] lt,
                     input int len, input int pat, input int gap, input int nfr,
                     input bit err, input bit disturb);
    for (int f = 0; f < nfr; f++) build(d, s, lt, len, pat, err);
    exp_gap = (gap < 12) ? 12 : gap;
    frames_seen = 0;
    @(negedge clk);
    cfg_dst = d; cfg_src = s; cfg_lentype = lt; cfg_pay_len = 11'(len);
    cfg_pattern = 2'(pat); cfg_gap = 8'(gap); cfg_frames = 16'(nfr); cfg_err_inj = err;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tx_sof && busy, "R2", "sof one cycle after start", int'({tx_sof, busy}), 3);
    if (disturb) begin
      repeat (30) @(negedge clk);
      cfg_pay_len = 11'd5; cfg_pattern = 2'd1; cfg_dst = '0; cfg_gap = 8'd40;
      cfg_err_inj = 1'b1; cfg_frames = 16'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "bytes still expected", exp_q.size(), 0);
    chk(frames_seen == nfr, disturb ? "R12" : "R11", "frames in run", frames_seen, nfr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_err_inj = 1'b0;
    cfg_dst = '0; cfg_src = '0; cfg_lentype = '0; cfg_pay_len = '0;
    cfg_pattern = '0; cfg_frames = 16'd1; cfg_gap = 8'd12;
    repeat (3) @(negedge clk);
    // R1
    chk({tx_valid, tx_sof, tx_eof, busy} == 4'b0, "R1", "reset outputs",
        int'({tx_valid, tx_sof, tx_eof, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tx_valid, busy} == 2'b0, "R1", "idle after reset", int'({tx_valid, busy}), 0);

    // R6 R7: short payload, incrementing, type field
    run(48'h0012_3456_789A, 48'h0A0B_0C0D_0E0F, 16'h0800, 20, 0, 12, 1, 1'b0, 1'b0);
    // R3 R4 R10: multicast dst, length replaced, 0xFF pattern, two frames, gap 20
    run(48'h0100_5E00_0001, 48'h0200_0000_0002, 16'd5, 100, 2, 20, 2, 1'b0, 1'b0);
    // R5 R7 R12: clamped length, PRBS pattern, gap below minimum, config disturbed
    run(48'hFFFF_FFFF_FFFF, 48'h1122_3344_5566, 16'h0000, 2000, 3, 3, 1, 1'b0, 1'b1);
    // R9 R6: empty payload with corrupted check sequence
    run(48'h0A00_0000_0001, 48'h0B00_0000_0002, 16'h0000, 0, 1, 12, 1, 1'b1, 1'b0);
    // R7: PRBS restarts each frame, three frames
    run(48'h0011_2233_4455, 48'h6677_8899_AABB, 16'h88B5, 60, 3, 15, 3, 1'b0, 1'b0);

    // R11: endless run when frame count is zero
    for (int f = 0; f < 3; f++) build(48'h0000_0000_0007, 48'h0000_0000_0008, 16'h0806, 10, 0, 1'b0);
    exp_gap = 12; frames_seen = 0;
    @(negedge clk);
    cfg_dst = 48'h7; cfg_src = 48'h8; cfg_lentype = 16'h0806; cfg_pay_len = 11'd10;
    cfg_pattern = 2'd0; cfg_gap = 8'd12; cfg_frames = 16'd0; cfg_err_inj = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (frames_seen < 3) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R11", "endless run still busy", int'(busy), 1);
    chk(exp_q.size() == 0, "R11", "endless run bytes", exp_q.size(), 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({tx_valid, busy} == 2'b0, "R1", "reset ends run", int'({tx_valid, busy}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule